// File: doc/BRIEF.md
# 1-Wire Slave Bit Front End

This block is the bit-level physical layer of a 1-Wire slave. It watches the open-drain line through a two-flop synchroniser, times every low pulse with a counter clocked by the system clock, and turns what it sees into one of two results. A short low is a time slot and yields one bit event. A long low is a bus reset, which the block reports and then answers with a presence pulse. In slots where the layer above wants to send a zero, the block stretches the master's low pulse with its own pulldown.

All durations are cycle counts derived from the clock frequency parameter `CLK_MHZ`. The `od_i` input picks standard or overdrive timing. Each reset report says whether the overdrive flag must be dropped, so the command layer can clear `od_i`. At standard speed a falling edge must persist before it counts. After each slot a hold-off window masks late glitches.

Top module: `ow_slave_phy`

## Requirements
- R1: While `rst_ni` is low and after its release with the line idle high, `pull_o`, `bit_valid_o` and `rst_o` are 0.
- R2: Every time slot yields exactly one single-cycle `bit_valid_o` pulse. `bit_o` is the synchronised line level taken 30 µs (standard) or 3 µs (overdrive) after the slot start: 0 for a low there, 1 for high. Master lows clearly shorter than that point give 1 and clearly longer ones give 0.
- R3: `tx_bit_i` is captured at slot start. When it is 0, `pull_o` is 1 for exactly 30 µs (standard) or 3 µs (overdrive) of cycles from slot start. When it is 1, `pull_o` stays 0 for the whole slot.
- R4: At standard speed, a low of 120 µs or more gives one `rst_o` pulse at its rising edge with `rst_std_o`=1. A shorter low is a slot and gives no `rst_o`.
- R5: In overdrive, a low longer than 16 µs is a reset. Below 480 µs it reports `rst_std_o`=0 (keep overdrive). At 480 µs or more it reports `rst_std_o`=1 (return to standard speed). A shorter low is a slot.
- R6: The presence pulse begins exactly 30 µs (standard) or 3 µs (overdrive) after the `rst_o` cycle. `pull_o` is then held 1 for exactly 120 µs (standard) or 10 µs (overdrive). The timing used is the speed the reset leaves in force.
- R7: At standard speed, line lows within 5 µs of the end of a slot are ignored. A low after that window starts a new slot. In overdrive there is no window.
- R8: At standard speed, a synchronised low lasting no more than 1 µs starts nothing. In overdrive, any synchronised low starts a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, `CLK_MHZ` MHz |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Raw 1-Wire line level, asynchronous |
| od_i | input | 1 | 1 selects overdrive timing |
| tx_bit_i | input | 1 | Bit to send in the next slot; 1 for write slots |
| pull_o | output | 1 | Pulldown enable for the open-drain driver |
| bit_valid_o | output | 1 | One-cycle pulse per decoded slot |
| bit_o | output | 1 | Decoded slot value, valid with `bit_valid_o` |
| rst_o | output | 1 | One-cycle pulse when a bus reset ends |
| rst_std_o | output | 1 | With `rst_o`: 1 means standard speed is required |

## Verification
Assertions check these properties on every cycle: bit events are single-cycle pulses and never coincide with a reset report; the slot state cannot be left while the hold-off window runs; the presence pulldown never runs past its length; a keep-overdrive report only follows a cycle with `od_i` set; and the edge filter only reports a low that was already low a cycle earlier. The exact sample thresholds, pulldown lengths, reset classification at both speeds, presence delay and glitch handling around the hold-off window depend on measured pulse lengths. Only the bench's swept scenarios can show those.

// File: rtl/ow_phy_pkg.sv
package ow_phy_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOW, ST_HIGH, ST_PDH, ST_PDL, ST_PREL
  } phy_st_e;

  // durations in microseconds, scaled by the clock parameter in the top
  localparam int unsigned STD_SAMP_US = 30;
  localparam int unsigned OD_SAMP_US  = 3;
  localparam int unsigned STD_PULL_US = 30;
  localparam int unsigned OD_PULL_US  = 3;
  localparam int unsigned STD_RMIN_US = 120;
  localparam int unsigned OD_RMIN_US  = 16;
  localparam int unsigned LONG_RST_US = 480;
  localparam int unsigned STD_PDH_US  = 30;
  localparam int unsigned OD_PDH_US   = 3;
  localparam int unsigned STD_PDL_US  = 120;
  localparam int unsigned OD_PDL_US   = 10;
  localparam int unsigned STD_HOLD_US = 5;
  localparam int unsigned STD_FILT_US = 1;
endpackage

// File: rtl/ow_sync.sv
module ow_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/ow_low_filter.sv
module ow_low_filter #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_i,
  input  logic [CW-1:0] len_i,
  output logic          low_o
);
  logic [CW-1:0] run_q;

  // counts earlier consecutive low cycles, saturating at len_i
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            run_q <= '0;
    else if (line_i)        run_q <= '0;
    else if (run_q < len_i) run_q <= run_q + 1'b1;
  end

  assign low_o = !line_i && (run_q >= len_i);

  p_filt_persist_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_o && len_i != '0) |-> $past(!line_i));
endmodule

// File: rtl/ow_slave_phy.sv
module ow_slave_phy
  import ow_phy_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic od_i,
  input  logic tx_bit_i,
  output logic pull_o,
  output logic bit_valid_o,
  output logic bit_o,
  output logic rst_o,
  output logic rst_std_o
);
  localparam int unsigned LONG_C = LONG_RST_US * CLK_MHZ;
  localparam int unsigned CW     = $clog2(LONG_C + 1);

  localparam logic [CW-1:0] C_LONG     = CW'(LONG_C);
  localparam logic [CW-1:0] C_STD_SAMP = CW'(STD_SAMP_US * CLK_MHZ);
  localparam logic [CW-1:0] C_OD_SAMP  = CW'(OD_SAMP_US * CLK_MHZ);
  localparam logic [CW-1:0] C_STD_PULL = CW'(STD_PULL_US * CLK_MHZ);
  localparam logic [CW-1:0] C_OD_PULL  = CW'(OD_PULL_US * CLK_MHZ);
  localparam logic [CW-1:0] C_STD_RMIN = CW'(STD_RMIN_US * CLK_MHZ);
  localparam logic [CW-1:0] C_OD_RMIN  = CW'(OD_RMIN_US * CLK_MHZ);
  localparam logic [CW-1:0] C_STD_PDH  = CW'(STD_PDH_US * CLK_MHZ);
  localparam logic [CW-1:0] C_OD_PDH   = CW'(OD_PDH_US * CLK_MHZ);
  localparam logic [CW-1:0] C_STD_PDL  = CW'(STD_PDL_US * CLK_MHZ);
  localparam logic [CW-1:0] C_OD_PDL   = CW'(OD_PDL_US * CLK_MHZ);
  localparam logic [CW-1:0] C_STD_HOLD = CW'(STD_HOLD_US * CLK_MHZ);
  localparam logic [CW-1:0] C_STD_FILT = CW'(STD_FILT_US * CLK_MHZ);

  logic          line_s, fall_low;
  logic [CW-1:0] samp_len, pull_len, rmin_len, hold_len, filt_len, pdh_len, pdl_len;
  phy_st_e       st_q;
  logic [CW-1:0] cnt_q, hold_q;
  logic          smp_q, tx_q, pod_q;
  logic          bit_v_q, bit_q, rst_q, rst_std_q;
  logic          in_slot;

  ow_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(line_i), .q_o(line_s)
  );

  ow_low_filter #(.CW(CW)) u_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(line_s), .len_i(filt_len), .low_o(fall_low)
  );

  always_comb begin
    samp_len = od_i ? C_OD_SAMP : C_STD_SAMP;
    pull_len = od_i ? C_OD_PULL : C_STD_PULL;
    rmin_len = od_i ? C_OD_RMIN : C_STD_RMIN;
    hold_len = od_i ? '0 : C_STD_HOLD;
    filt_len = od_i ? '0 : C_STD_FILT;
    // presence uses the speed the reset left in force
    pdh_len  = pod_q ? C_OD_PDH : C_STD_PDH;
    pdl_len  = pod_q ? C_OD_PDL : C_STD_PDL;
  end

  assign in_slot = (st_q == ST_LOW) || (st_q == ST_HIGH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      hold_q    <= '0;
      smp_q     <= 1'b0;
      tx_q      <= 1'b1;
      pod_q     <= 1'b0;
      bit_v_q   <= 1'b0;
      bit_q     <= 1'b0;
      rst_q     <= 1'b0;
      rst_std_q <= 1'b0;
    end else begin
      bit_v_q <= 1'b0;
      rst_q   <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (fall_low) begin
            st_q  <= ST_LOW;
            cnt_q <= '0;
            smp_q <= 1'b0;
            tx_q  <= tx_bit_i;
          end
        end
        ST_LOW, ST_HIGH: begin
          if (cnt_q != C_LONG) cnt_q <= cnt_q + 1'b1;
          if (!smp_q && cnt_q == samp_len) begin
            bit_v_q <= 1'b1;
            bit_q   <= line_s;
            smp_q   <= 1'b1;
          end
          if (st_q == ST_LOW) begin
            if (line_s) begin
              if (cnt_q >= rmin_len) begin
                rst_q     <= 1'b1;
                rst_std_q <= !od_i || (cnt_q >= C_LONG);
                pod_q     <= od_i && (cnt_q < C_LONG);
                st_q      <= ST_PDH;
                cnt_q     <= '0;
              end else begin
                st_q   <= ST_HIGH;
                hold_q <= '0;
              end
            end
          end else begin
            if (hold_q < hold_len) hold_q <= hold_q + 1'b1;
            else if (smp_q) begin
              if (fall_low) begin
                st_q  <= ST_LOW;
                cnt_q <= '0;
                smp_q <= 1'b0;
                tx_q  <= tx_bit_i;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
        end
        ST_PDH: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == pdh_len - 1'b1) begin
            st_q  <= ST_PDL;
            cnt_q <= '0;
          end
        end
        ST_PDL: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == pdl_len - 1'b1) st_q <= ST_PREL;
        end
        ST_PREL: begin
          if (line_s) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign pull_o      = (st_q == ST_PDL) || (in_slot && !tx_q && cnt_q < pull_len);
  assign bit_valid_o = bit_v_q;
  assign bit_o       = bit_q;
  assign rst_o       = rst_q;
  assign rst_std_o   = rst_std_q;

  p_bit_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |=> !bit_valid_o);

  p_no_bit_on_reset_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bit_valid_o && rst_o));

  p_keep_od_needs_od_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_o && !rst_std_o) |-> $past(od_i));

  p_hold_window_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HIGH && hold_q < hold_len) |=> st_q == ST_HIGH);

  p_pres_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PDL) |-> cnt_q < pdl_len);

  p_pres_order_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PDH) |=> (st_q == ST_PDH || st_q == ST_PDL));
endmodule

// File: tb/ow_slave_phy_test.sv
module ow_slave_phy_test;
  localparam int CLK_NS = 10;
  localparam int MHZ    = 2;
  localparam int WD     = 150000;

  localparam int STD_PULL = 30 * MHZ;
  localparam int OD_PULL  = 3 * MHZ;
  localparam int STD_PDH  = 30 * MHZ;
  localparam int OD_PDH   = 3 * MHZ;
  localparam int STD_PDL  = 120 * MHZ;
  localparam int OD_PDL   = 10 * MHZ;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_low = 1'b0;
  logic od = 1'b0;
  logic tx_bit = 1'b1;
  logic line;
  logic pull_o, bit_valid_o, bit_o, rst_o, rst_std_o;

  int n_chk = 0, n_bad = 0;
  int n_bit = 0, n_rst = 0, n_pull = 0, cyc = 0;
  int rst_cyc = 0, rise_cyc = 0;
  logic last_bit = 1'b0, last_std = 1'b0, prev_pull = 1'b0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  assign line = !(m_low || pull_o);

  ow_slave_phy #(.CLK_MHZ(MHZ)) uut (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .od_i(od), .tx_bit_i(tx_bit),
    .pull_o(pull_o), .bit_valid_o(bit_valid_o), .bit_o(bit_o),
    .rst_o(rst_o), .rst_std_o(rst_std_o)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (bit_valid_o) begin n_bit++; last_bit = bit_o; end
      if (rst_o) begin n_rst++; last_std = rst_std_o; rst_cyc = cyc; end
      if (pull_o) n_pull++;
      if (pull_o && !prev_pull) rise_cyc = cyc;
      prev_pull = pull_o;
      cyc++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic low_for(input int n);
    @(negedge clk); m_low = 1'b1;
    repeat (n) @(negedge clk);
    m_low = 1'b0;
  endtask

  task automatic slot(input int n, input logic tx, input int per);
    tx_bit = tx;
    low_for(n);
    repeat (per - n) @(negedge clk);
    tx_bit = 1'b1;
  endtask

  task automatic reset_case(input int n, input logic exp_std, input int pdh, input int pdl,
                            input string req);
    int r0, p0;
    r0 = n_rst;
    tx_bit = 1'b1;
    low_for(n);
    p0 = n_pull;
    repeat (STD_PDH + STD_PDL + 80) @(negedge clk);
    chk(n_rst - r0 == 1, req, n_rst - r0, 1);
    chk(last_std == exp_std, req, int'(last_std), int'(exp_std));
    chk(n_pull - p0 == pdl, "R6 presence length", n_pull - p0, pdl);
    chk(rise_cyc - rst_cyc == pdh, "R6 presence delay", rise_cyc - rst_cyc, pdh);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", WD, 0);
    finish_run();
  end

  initial begin
    int b0, r0, p0;
    repeat (3) @(negedge clk);
    chk(pull_o == 1'b0, "R1 pull in reset", int'(pull_o), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(pull_o == 1'b0, "R1 pull idle", int'(pull_o), 0);
    chk(bit_valid_o == 1'b0 && n_bit == 0, "R1 bit idle", n_bit, 0);
    chk(rst_o == 1'b0 && n_rst == 0, "R1 reset idle", n_rst, 0);

    // R8 edge filter
    od = 1'b0; b0 = n_bit;
    slot(2, 1'b1, 150);
    chk(n_bit == b0, "R8 std short low ignored", n_bit - b0, 0);
    od = 1'b1; b0 = n_bit;
    slot(2, 1'b1, 40);
    chk(n_bit - b0 == 1 && last_bit == 1'b1, "R8 od short low seen", n_bit - b0, 1);

    // R2 standard sweep, threshold near 64 cycles
    od = 1'b0;
    for (int n = 6; n <= 110; n += 4) begin
      if (n >= 60 && n <= 68) continue;
      b0 = n_bit; r0 = n_rst;
      slot(n, 1'b1, 160);
      chk(n_bit - b0 == 1 && last_bit == (n < 64) && n_rst == r0,
          "R2 std write slot", int'(last_bit), int'(n < 64));
    end
    // R2 overdrive sweep, threshold near 8 cycles
    od = 1'b1;
    for (int n = 2; n <= 24; n++) begin
      if (n >= 7 && n <= 9) continue;
      b0 = n_bit; r0 = n_rst;
      slot(n, 1'b1, 40);
      chk(n_bit - b0 == 1 && last_bit == (n < 8), "R2 od write slot",
          int'(last_bit), int'(n < 8));
      chk(n_rst == r0, "R5 od short low no reset", n_rst - r0, 0);
    end

    // R3 read slots
    od = 1'b0;
    p0 = n_pull; b0 = n_bit;
    slot(8, 1'b0, 160);
    chk(n_pull - p0 == STD_PULL, "R3 std read zero pull", n_pull - p0, STD_PULL);
    chk(last_bit == 1'b0 && n_bit - b0 == 1, "R3 std read zero bit", int'(last_bit), 0);
    p0 = n_pull;
    slot(8, 1'b1, 160);
    chk(n_pull == p0, "R3 std read one pull", n_pull - p0, 0);
    od = 1'b1;
    p0 = n_pull;
    slot(4, 1'b0, 40);
    chk(n_pull - p0 == OD_PULL, "R3 od read zero pull", n_pull - p0, OD_PULL);
    chk(last_bit == 1'b0, "R3 od read zero bit", int'(last_bit), 0);
    p0 = n_pull;
    slot(4, 1'b1, 40);
    chk(n_pull == p0, "R3 od read one pull", n_pull - p0, 0);

    // R4 standard resets
    od = 1'b0; r0 = n_rst;
    slot(200, 1'b1, 300);
    chk(n_rst == r0, "R4 std 100us no reset", n_rst - r0, 0);
    chk(last_bit == 1'b0, "R4 std 100us bit", int'(last_bit), 0);
    reset_case(300, 1'b1, STD_PDH, STD_PDL, "R4 std reset");

    // R5 overdrive resets
    od = 1'b1;
    reset_case(100, 1'b0, OD_PDH, OD_PDL, "R5 od reset keep");
    reset_case(40, 1'b0, OD_PDH, OD_PDL, "R5 od reset 20us");
    reset_case(1000, 1'b1, STD_PDH, STD_PDL, "R5 od long reset");
    od = 1'b0;

    // R7 hold-off at standard speed
    tx_bit = 1'b1; b0 = n_bit;
    low_for(80);
    repeat (2) @(negedge clk);
    low_for(5);
    repeat (150) @(negedge clk);
    chk(n_bit - b0 == 1, "R7 std glitch in hold-off", n_bit - b0, 1);
    b0 = n_bit;
    low_for(80);
    repeat (14) @(negedge clk);
    low_for(5);
    repeat (150) @(negedge clk);
    chk(n_bit - b0 == 2 && last_bit == 1'b1, "R7 std low after hold-off", n_bit - b0, 2);
    // R7 no hold-off in overdrive
    od = 1'b1; b0 = n_bit;
    low_for(14);
    repeat (2) @(negedge clk);
    low_for(3);
    repeat (40) @(negedge clk);
    chk(n_bit - b0 == 2 && last_bit == 1'b1, "R7 od glitch is slot", n_bit - b0, 2);

    finish_run();
  end
endmodule